// File: doc/BRIEF.md
# Read Completion Splitter

This block takes one accepted memory read request and turns it into the series of completion-with-data headers that return its data. The request supplies the dword address bits that matter for splitting, the length in dwords, the first and last byte enables, the tag and the requester ID. The block then presents one header per cycle on a valid/ready output. Each header carries the dword length of that piece, the number of bytes still owed to the requester, and the low seven bits of the address where the piece starts.

A piece is never longer than the configured maximum payload. A piece that has to be cut is shortened so that it ends on a 128-byte read completion boundary. Each header also carries the dword offset of the piece within the request and a last flag. An external data path can use the offset and length to fetch the payload. The block accepts a new request only after the final piece of the previous one has been taken.

Top module: `rd_cpl_splitter`

## Requirements
- R1: After reset, `req_ready` is 1 and `cpl_valid` is 0.
- R2: A request is taken on a clock edge where `req_valid` and `req_ready` are both 1. The first header is valid after that edge with dword offset 0. `req_ready` stays 0 until the final header has been taken, and requests offered in that time are not taken.
- R3: The largest piece in dwords is 32 shifted left by `max_payload_code`, which is captured with the request. Codes 6 and 7 act as code 5 (1024 dwords). A request that fits this limit returns as a single piece.
- R4: While the dwords still owed exceed the largest piece, the piece length is that maximum minus address bits 6:2 of the current address. Every piece except the last therefore ends on a 128-byte boundary.
- R5: The starting address is the request dword address plus the index of the lowest set bit of the first byte enables, or plus 0 if they are all zero. `cpl_lower_addr` is bits 6:0 of the current address.
- R6: The total byte count for a one-dword request is the span from the lowest to the highest set first-enable bit, or 1 when no bit is set. For a longer request it is length×4 minus the lowest first-enable index minus (3 minus the highest last-enable index). `cpl_byte_count` is this total minus the bytes already returned.
- R7: After each piece, the address and the bytes returned both advance by length×4 minus address bits 1:0. `cpl_dw_offset` is the sum of the earlier piece lengths. Pieces are produced until that sum equals the request length, and `cpl_last` marks the final piece.
- R8: Every header copies the tag and requester ID of the request. It carries `completer_id` as captured when the request was taken, and a status of 3'b000 (successful).
- R9: While `cpl_valid` is 1 and `cpl_ready` is 0, every header output holds its value.
- R10: A one-dword request with first byte enables 4'b0000 returns exactly one piece, with byte count 1 and lower address equal to the request dword address times 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block can take a request |
| req_len_dw | input | LEN_W | Request length in dwords, 1 to 1024 |
| req_addr_dw | input | 5 | Request address bits 6:2 |
| req_first_be | input | 4 | First dword byte enables |
| req_last_be | input | 4 | Last dword byte enables (non-zero when length > 1) |
| req_tag | input | 8 | Request tag |
| req_requester_id | input | 16 | Requester ID |
| completer_id | input | 16 | This device's ID, captured with the request |
| max_payload_code | input | 3 | Encoded maximum payload size |
| cpl_valid | output | 1 | Header valid |
| cpl_ready | input | 1 | Header taken |
| cpl_len_dw | output | LEN_W | Piece length in dwords |
| cpl_byte_count | output | LEN_W+2 | Bytes still owed, including this piece |
| cpl_lower_addr | output | 7 | Low address bits of the piece start |
| cpl_tag | output | 8 | Copied tag |
| cpl_requester_id | output | 16 | Copied requester ID |
| cpl_completer_id | output | 16 | Captured completer ID |
| cpl_status | output | 3 | Completion status, always successful |
| cpl_dw_offset | output | LEN_W | Dword offset of the piece within the request |
| cpl_last | output | 1 | Final piece of the request |

## Verification
The splitter is driven with several requests. A request of 40 dwords with partial enables at both ends shows the first-byte offset and both trims in the byte count. A 256-dword aligned request shows equal pieces at the payload limit. A 100-dword request that starts one dword below a 128-byte boundary forces a one-dword first piece and tells the boundary cut apart from a plain payload cut. One-dword requests with empty and mid-word enables check the byte-count corner cases. A 1024-dword request with an out-of-range payload code checks the clamp. A stalled consumer checks that the header holds and that no second request is taken.

// File: rtl/rcs_pkg.sv
`timescale 1ns/1ps
package rcs_pkg;

    localparam int RCS_TAG_W = 8;
    localparam int RCS_ID_W  = 16;
    localparam int RCS_LA_W  = 7;
    localparam int RCS_MPS_MAX = 5;
    localparam logic [2:0] RCS_STATUS_OK = 3'b000;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_SEND = 1'b1
    } rcs_state_t;

    typedef struct packed {
        logic [RCS_TAG_W-1:0] tag;
        logic [RCS_ID_W-1:0]  req_id;
        logic [RCS_ID_W-1:0]  cpl_id;
        logic [2:0]           mps;
    } rcs_ctx_t;

    // index of the lowest enabled byte, 0 when none
    function automatic logic [1:0] be_low_idx(input logic [3:0] be);
        if (be[0])      return 2'd0;
        else if (be[1]) return 2'd1;
        else if (be[2]) return 2'd2;
        else if (be[3]) return 2'd3;
        else            return 2'd0;
    endfunction

    // index of the highest enabled byte, 0 when none
    function automatic logic [1:0] be_high_idx(input logic [3:0] be);
        if (be[3])      return 2'd3;
        else if (be[2]) return 2'd2;
        else if (be[1]) return 2'd1;
        else            return 2'd0;
    endfunction

    function automatic logic [2:0] mps_clamp(input logic [2:0] code);
        return (code > 3'(RCS_MPS_MAX)) ? 3'(RCS_MPS_MAX) : code;
    endfunction

endpackage

// File: rtl/rcs_req_decode.sv
`timescale 1ns/1ps
module rcs_req_decode
    import rcs_pkg::*;
#(
    parameter int LEN_W = 11
) (
    input  logic [LEN_W-1:0]    len_dw,
    input  logic [3:0]          first_be,
    input  logic [3:0]          last_be,
    input  logic [4:0]          addr_dw,
    output logic [RCS_LA_W-1:0] start_la,
    output logic [LEN_W+1:0]    total_bytes
);
    localparam int BC_W = LEN_W + 2;

    logic [1:0] lo_first;
    logic [1:0] hi_first;
    logic [1:0] hi_last;

    always_comb begin
        lo_first = be_low_idx(first_be);
        hi_first = be_high_idx(first_be);
        hi_last  = be_high_idx(last_be);
        start_la = {addr_dw, lo_first};
        if (len_dw == LEN_W'(1)) begin
            if (first_be == 4'b0000)
                total_bytes = BC_W'(1);
            else
                total_bytes = BC_W'(hi_first) - BC_W'(lo_first) + BC_W'(1);
        end else begin
            total_bytes = {len_dw, 2'b00} - BC_W'(lo_first)
                          - (BC_W'(3) - BC_W'(hi_last));
        end
    end
endmodule

// File: rtl/rcs_piece_calc.sv
`timescale 1ns/1ps
module rcs_piece_calc
    import rcs_pkg::*;
#(
    parameter int LEN_W = 11
) (
    input  logic [LEN_W-1:0] rem_dw,
    input  logic [2:0]       mps_code,
    input  logic [4:0]       la_dw,
    output logic [LEN_W-1:0] piece_dw
);
    logic [LEN_W-1:0] max_dw;

    always_comb begin
        max_dw = LEN_W'(32) << mps_clamp(mps_code);
        if (rem_dw > max_dw)
            piece_dw = max_dw - LEN_W'(la_dw);   // pull back to 128-byte boundary
        else
            piece_dw = rem_dw;
    end
endmodule

// File: rtl/rd_cpl_splitter.sv
`timescale 1ns/1ps
module rd_cpl_splitter
    import rcs_pkg::*;
#(
    parameter int LEN_W = 11
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  req_valid,
    output logic                  req_ready,
    input  logic [LEN_W-1:0]      req_len_dw,
    input  logic [4:0]            req_addr_dw,
    input  logic [3:0]            req_first_be,
    input  logic [3:0]            req_last_be,
    input  logic [RCS_TAG_W-1:0]  req_tag,
    input  logic [RCS_ID_W-1:0]   req_requester_id,
    input  logic [RCS_ID_W-1:0]   completer_id,
    input  logic [2:0]            max_payload_code,
    output logic                  cpl_valid,
    input  logic                  cpl_ready,
    output logic [LEN_W-1:0]      cpl_len_dw,
    output logic [LEN_W+1:0]      cpl_byte_count,
    output logic [RCS_LA_W-1:0]   cpl_lower_addr,
    output logic [RCS_TAG_W-1:0]  cpl_tag,
    output logic [RCS_ID_W-1:0]   cpl_requester_id,
    output logic [RCS_ID_W-1:0]   cpl_completer_id,
    output logic [2:0]            cpl_status,
    output logic [LEN_W-1:0]      cpl_dw_offset,
    output logic                  cpl_last
);
    localparam int BC_W = LEN_W + 2;

    rcs_state_t          state_q;
    rcs_ctx_t            ctx_q;
    logic [LEN_W-1:0]    len_q;
    logic [LEN_W-1:0]    sent_dw_q;
    logic [BC_W-1:0]     sent_b_q;
    logic [BC_W-1:0]     total_q;
    logic [RCS_LA_W-1:0] la_q;

    logic [RCS_LA_W-1:0] dec_la;
    logic [BC_W-1:0]     dec_total;
    logic [LEN_W-1:0]    rem_dw;
    logic [LEN_W-1:0]    piece_dw;
    logic                accept;
    logic                fire;
    logic                is_last;

    rcs_req_decode #(.LEN_W(LEN_W)) u_dec (
        .len_dw      (req_len_dw),
        .first_be    (req_first_be),
        .last_be     (req_last_be),
        .addr_dw     (req_addr_dw),
        .start_la    (dec_la),
        .total_bytes (dec_total)
    );

    assign rem_dw = len_q - sent_dw_q;

    rcs_piece_calc #(.LEN_W(LEN_W)) u_piece (
        .rem_dw   (rem_dw),
        .mps_code (ctx_q.mps),
        .la_dw    (la_q[6:2]),
        .piece_dw (piece_dw)
    );

    assign accept  = req_valid && req_ready;
    assign fire    = cpl_valid && cpl_ready;
    assign is_last = (piece_dw == rem_dw);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_IDLE;
            ctx_q     <= '0;
            len_q     <= '0;
            sent_dw_q <= '0;
            sent_b_q  <= '0;
            total_q   <= '0;
            la_q      <= '0;
        end else if (accept) begin
            state_q   <= ST_SEND;
            ctx_q     <= '{tag: req_tag, req_id: req_requester_id,
                           cpl_id: completer_id, mps: max_payload_code};
            len_q     <= req_len_dw;
            sent_dw_q <= '0;
            sent_b_q  <= '0;
            total_q   <= dec_total;
            la_q      <= dec_la;
        end else if (fire) begin
            if (is_last)
                state_q <= ST_IDLE;
            sent_dw_q <= sent_dw_q + piece_dw;
            sent_b_q  <= sent_b_q + {piece_dw, 2'b00} - BC_W'(la_q[1:0]);
            la_q      <= {la_q[6:2] + piece_dw[4:0], 2'b00};
        end
    end

    assign req_ready        = (state_q == ST_IDLE);
    assign cpl_valid        = (state_q == ST_SEND);
    assign cpl_len_dw       = piece_dw;
    assign cpl_byte_count   = total_q - sent_b_q;
    assign cpl_lower_addr   = la_q;
    assign cpl_tag          = ctx_q.tag;
    assign cpl_requester_id = ctx_q.req_id;
    assign cpl_completer_id = ctx_q.cpl_id;
    assign cpl_status       = RCS_STATUS_OK;
    assign cpl_dw_offset    = sent_dw_q;
    assign cpl_last         = is_last;

endmodule

// File: rtl/rcs_checker.sv
`timescale 1ns/1ps
module rcs_checker #(
    parameter int LEN_W = 11
) (
    input logic             clk,
    input logic             rst,
    input logic             req_valid,
    input logic             req_ready,
    input logic             cpl_valid,
    input logic             cpl_ready,
    input logic [LEN_W-1:0] cpl_len_dw,
    input logic [LEN_W+1:0] cpl_byte_count,
    input logic [6:0]       cpl_lower_addr,
    input logic [7:0]       cpl_tag,
    input logic [LEN_W-1:0] cpl_dw_offset,
    input logic             cpl_last
);
    logic [4:0]       end_dw;
    logic [LEN_W+2:0] bc_span;
    logic [LEN_W+2:0] len_bytes;

    assign end_dw    = cpl_lower_addr[6:2] + cpl_len_dw[4:0];
    assign bc_span   = (LEN_W+3)'(cpl_byte_count) + (LEN_W+3)'(3)
                       + (LEN_W+3)'(cpl_lower_addr[1:0]);
    assign len_bytes = (LEN_W+3)'({cpl_len_dw, 2'b00});

    AST_START_AT_ZERO: assert property (@(posedge clk) disable iff (rst)
        req_valid && req_ready |=> cpl_valid && cpl_dw_offset == '0); // R2

    AST_RCB_END: assert property (@(posedge clk) disable iff (rst)
        cpl_valid && !cpl_last |-> end_dw == 5'd0); // R4

    AST_BC_COVERS_LEN: assert property (@(posedge clk) disable iff (rst)
        cpl_valid |-> bc_span >= len_bytes); // R6

    AST_OFFSET_ADVANCE: assert property (@(posedge clk) disable iff (rst)
        cpl_valid && cpl_ready && !cpl_last |=>
            cpl_valid && cpl_dw_offset == $past(cpl_dw_offset) + $past(cpl_len_dw)); // R7

    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
        cpl_valid && cpl_ready && cpl_last |=> req_ready && !cpl_valid); // R7

    AST_HOLD_STALL: assert property (@(posedge clk) disable iff (rst)
        cpl_valid && !cpl_ready |=> cpl_valid && $stable(cpl_len_dw)
            && $stable(cpl_byte_count) && $stable(cpl_lower_addr)
            && $stable(cpl_tag) && $stable(cpl_dw_offset)); // R9

endmodule

bind rd_cpl_splitter rcs_checker #(.LEN_W(LEN_W)) u_chk (
    .clk            (clk),
    .rst            (rst),
    .req_valid      (req_valid),
    .req_ready      (req_ready),
    .cpl_valid      (cpl_valid),
    .cpl_ready      (cpl_ready),
    .cpl_len_dw     (cpl_len_dw),
    .cpl_byte_count (cpl_byte_count),
    .cpl_lower_addr (cpl_lower_addr),
    .cpl_tag        (cpl_tag),
    .cpl_dw_offset  (cpl_dw_offset),
    .cpl_last       (cpl_last)
);

// File: tb/rd_cpl_splitter_tb.sv
`timescale 1ns/1ps
module rd_cpl_splitter_tb;
    localparam int LEN_W = 11;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic [LEN_W-1:0]  req_len_dw = '0;
    logic [4:0]        req_addr_dw = '0;
    logic [3:0]        req_first_be = '0;
    logic [3:0]        req_last_be = '0;
    logic [7:0]        req_tag = '0;
    logic [15:0]       req_requester_id = '0;
    logic [15:0]       completer_id = '0;
    logic [2:0]        max_payload_code = '0;
    logic              cpl_valid;
    logic              cpl_ready = 1'b1;
    logic [LEN_W-1:0]  cpl_len_dw;
    logic [LEN_W+1:0]  cpl_byte_count;
    logic [6:0]        cpl_lower_addr;
    logic [7:0]        cpl_tag;
    logic [15:0]       cpl_requester_id;
    logic [15:0]       cpl_completer_id;
    logic [2:0]        cpl_status;
    logic [LEN_W-1:0]  cpl_dw_offset;
    logic              cpl_last;

    int n_checks = 0;
    int n_fail   = 0;

    always #4 clk = ~clk;

    rd_cpl_splitter #(.LEN_W(LEN_W)) u_dut (.*);

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
        end
    endtask

    task automatic send_req(input int len, input int adw, input int fbe, input int lbe,
                            input int code, input int tag, input int rid, input int cid);
        @(negedge clk);
        chk(req_ready == 1'b1, "R2 ready before request", int'(req_ready), 1);
        req_len_dw       = LEN_W'(len);
        req_addr_dw      = 5'(adw);
        req_first_be     = 4'(fbe);
        req_last_be      = 4'(lbe);
        max_payload_code = 3'(code);
        req_tag          = 8'(tag);
        req_requester_id = 16'(rid);
        completer_id     = 16'(cid);
        req_valid        = 1'b1;
        @(negedge clk);
        req_valid        = 1'b0;
        completer_id     = 16'hFFFF;   // captured value must persist (R8)
    endtask

    // checks the header present now, then lets it be taken
    task automatic expect_cpl(input string rq, input int len, input int bc, input int la,
                              input int off, input int last, input int tag, input int rid,
                              input int cid);
        for (int w = 0; w < 50 && !cpl_valid; w++) @(negedge clk);
        chk(cpl_valid == 1'b1, {rq, " valid"}, int'(cpl_valid), 1);
        chk(cpl_len_dw == LEN_W'(len), {rq, " length"}, int'(cpl_len_dw), len);
        chk(cpl_byte_count == (LEN_W+2)'(bc), {rq, " byte count"}, int'(cpl_byte_count), bc);
        chk(cpl_lower_addr == 7'(la), {rq, " lower address"}, int'(cpl_lower_addr), la);
        chk(cpl_dw_offset == LEN_W'(off), {rq, " R7 offset"}, int'(cpl_dw_offset), off);
        chk(cpl_last == 1'(last), {rq, " R7 last"}, int'(cpl_last), last);
        chk(cpl_tag == 8'(tag) && cpl_requester_id == 16'(rid), {rq, " R8 ids"},
            int'({cpl_tag, cpl_requester_id}), (tag << 16) | rid);
        chk(cpl_completer_id == 16'(cid), {rq, " R8 completer"}, int'(cpl_completer_id), cid);
        chk(cpl_status == 3'b000, {rq, " R8 status"}, int'(cpl_status), 0);
        chk(req_ready == 1'b0, {rq, " R2 busy"}, int'(req_ready), 0);
        cpl_ready = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_reset();
        chk(req_ready == 1'b1, "R1 req_ready after reset", int'(req_ready), 1);
        chk(cpl_valid == 1'b0, "R1 cpl_valid after reset", int'(cpl_valid), 0);
    endtask

    task automatic t_two_piece();
        send_req(40, 3, 'hC, 'h3, 0, 'h21, 'h0100, 'h0300);
        expect_cpl("R4 R5 R6 piece0", 29, 156, 'h0E, 0, 0, 'h21, 'h0100, 'h0300);
        expect_cpl("R6 R7 piece1", 11, 42, 'h00, 29, 1, 'h21, 'h0100, 'h0300);
        chk(req_ready == 1'b1 && cpl_valid == 1'b0, "R7 idle after last",
            int'({req_ready, cpl_valid}), 2);
    endtask

    task automatic t_aligned_mps();
        send_req(256, 0, 'hF, 'hF, 1, 'h33, 'h0A0B, 'h0C0D);
        for (int i = 0; i < 4; i++)
            expect_cpl("R3 equal piece", 64, 1024 - 256 * i, 0, 64 * i, (i == 3) ? 1 : 0,
                       'h33, 'h0A0B, 'h0C0D);
    endtask

    task automatic t_rcb_corner();
        send_req(100, 31, 'hF, 'hF, 0, 'h44, 'h1234, 'h5678);
        expect_cpl("R4 short head", 1, 400, 'h7C, 0, 0, 'h44, 'h1234, 'h5678);
        expect_cpl("R4 piece1", 32, 396, 0, 1, 0, 'h44, 'h1234, 'h5678);
        expect_cpl("R4 piece2", 32, 268, 0, 33, 0, 'h44, 'h1234, 'h5678);
        expect_cpl("R4 piece3", 32, 140, 0, 65, 0, 'h44, 'h1234, 'h5678);
        expect_cpl("R4 R7 tail", 3, 12, 0, 97, 1, 'h44, 'h1234, 'h5678);
    endtask

    task automatic t_single_zero_be();
        send_req(1, 9, 'h0, 'h0, 0, 'h55, 'h0001, 'h0002);
        expect_cpl("R10 zero enables", 1, 1, 'h24, 0, 1, 'h55, 'h0001, 'h0002);
        chk(cpl_valid == 1'b0, "R10 single piece only", int'(cpl_valid), 0);
    endtask

    task automatic t_single_mid_be();
        send_req(1, 5, 'h6, 'h0, 0, 'h66, 'h0003, 'h0004);
        expect_cpl("R5 R6 middle enables", 1, 2, 'h15, 0, 1, 'h66, 'h0003, 'h0004);
    endtask

    task automatic t_clamp();
        send_req(1024, 0, 'hF, 'hF, 6, 'h77, 'h0005, 'h0006);
        expect_cpl("R3 clamp code 6", 1024, 4096, 0, 0, 1, 'h77, 'h0005, 'h0006);
    endtask

    task automatic t_backpressure();
        cpl_ready = 1'b0;
        send_req(40, 3, 'hC, 'h3, 0, 'h88, 'h0F0F, 'h0300);
        req_tag   = 8'h99;
        req_valid = 1'b1;      // must not be taken while busy
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk(cpl_valid && cpl_len_dw == LEN_W'(29) && cpl_byte_count == 13'd156,
                "R9 header held", int'(cpl_len_dw), 29);
            chk(cpl_tag == 8'h88 && req_ready == 1'b0, "R2 second request refused",
                int'(cpl_tag), 'h88);
        end
        expect_cpl("R9 after stall 0", 29, 156, 'h0E, 0, 0, 'h88, 'h0F0F, 'h0300);
        req_valid = 1'b0;
        expect_cpl("R9 after stall 1", 11, 42, 'h00, 29, 1, 'h88, 'h0F0F, 'h0300);
    endtask

    initial begin
        #(8 * 200000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_two_piece();
        t_aligned_mps();
        t_rcb_corner();
        t_single_zero_be();
        t_single_mid_be();
        t_clamp();
        t_backpressure();
        repeat (2) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule